// File: doc/BRIEF.md
# Key-Guarded Byte Store Controller

This block puts a small byte-wide non-volatile-style store behind four registers on a simple register bus. Software loads an address register and a data register, then asks for a read or a write through a control register. A read moves the addressed byte into the data register within one cycle. A write is accepted only after a two-byte key has been written to a write-only key register and the control write also carries the write-enable bit. The write then runs for a fixed, parameterised number of clock cycles before the byte lands in the array.

Completion of a write sets a flag that stays set until software clears it; the flag can be routed to an interrupt line. The block has two resets. The power-on reset clears everything. The warm reset, meant for an external master clear or a watchdog, clears the working registers but keeps the error bit. If a warm reset cuts a write short, the error bit is set and the target byte is left untouched.

Register select codes: 0 = address, 1 = data, 2 = control, 3 = key. Control bits: bit 0 read request, bit 1 write busy, bit 2 write enable, bit 3 write error; bits 7..4 are always 0.

Top module: `dstore_ctl`

## Requirements
- R1: After the power-on reset the address, data and control registers read 0x00, the completion flag and interrupt are low, and the error bit is 0.
- R2: The key register (select 3) always reads 0x00, and control bits 7..4 always read 0.
- R3: A control write with bit 0 set, while no write is running, loads the data register with the byte at the current address one cycle later; a control read in the cycle after the request shows bit 0 as 1, and bit 0 reads 0 after that.
- R4: Software cannot clear bit 0 or bit 1 of the control register by writing 0, and a control write with bit 1 set and no valid key has no effect on the array or on bit 1.
- R5: A write starts only if 0x55 and then 0xAA were written to the key register and the next bus write is a control write with bits 2 and 1 both set; a wrong byte, a wrong order or a clear bit 2 leaves the array unchanged and bit 1 at 0.
- R6: A bus write to any other register between the two key bytes, or between 0xAA and the control write, cancels the key so that the control write starts nothing.
- R7: Once started, control bit 1 reads 1 for exactly WR_LAT consecutive cycles; as it clears, the data register byte is stored at the address register location and the completion flag is set.
- R8: While a write runs, bus writes to the address and data registers, a second start and a read request are ignored.
- R9: The completion flag stays set until flag_clr is pulsed, and irq equals the flag ANDed with irq_enable.
- R10: A warm reset during a write sets the error bit and leaves the target byte unchanged; a warm reset with no write running keeps the error bit; a normal completion clears it; the power-on reset clears it.
- R11: A warm reset clears the address register, data register, write enable, read request, busy bit and completion flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_por | input | 1 | Synchronous power-on reset, active high |
| rst_warm | input | 1 | Synchronous warm reset (master clear or watchdog), active high |
| bus_sel | input | 2 | Register select: 0 address, 1 data, 2 control, 3 key |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 8 | Write data |
| bus_re | input | 1 | Read strobe; data appears on bus_rdata after the next edge |
| bus_rdata | output | 8 | Registered read data |
| irq_enable | input | 1 | Routes the completion flag to irq |
| flag_clr | input | 1 | Clears the completion flag |
| done_flag | output | 1 | Write completion flag |
| irq | output | 1 | Completion interrupt |

## Verification
The bench writes every location of the array through the full key sequence, measures the busy time of each write against WR_LAT, and reads every byte back, so an address decode slip or an off-by-one in the latency counter shows up as a wrong byte or a wrong count. It then breaks the key in each way the requirements name (reversed bytes, a wrong second byte, a missing enable bit, an unrelated register write in either gap); a design whose key state machine forgot to reset would start a write and change the probed byte. During a running write it hammers the address, data and control registers, which catches a design that lets the target move mid-write or restarts on a second key. Finally it aborts a write with the warm reset, where a design that stored the byte anyway, cleared the error bit on reset, or lost it on an idle warm reset would read back wrongly.

// File: rtl/dstore_pkg.sv
package dstore_pkg;

  typedef enum logic [1:0] {
    RA_ADDR = 2'd0,
    RA_DATA = 2'd1,
    RA_CTRL = 2'd2,
    RA_KEY  = 2'd3
  } reg_sel_e;

  typedef enum logic [1:0] {
    K_IDLE = 2'd0,
    K_HALF = 2'd1,
    K_OPEN = 2'd2
  } key_state_e;

  localparam logic [7:0] KEY_FIRST  = 8'h55;
  localparam logic [7:0] KEY_SECOND = 8'hAA;

  localparam int C_RD   = 0;
  localparam int C_WR   = 1;
  localparam int C_WREN = 2;
  localparam int C_ERR  = 3;

endpackage

// File: rtl/dstore_unlock.sv
module dstore_unlock
  import dstore_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       bus_we,
  input  logic [1:0] bus_sel,
  input  logic [7:0] bus_wdata,
  output logic       armed
);

  key_state_e st;

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= K_IDLE;
    end else if (bus_we) begin
      if (bus_sel == RA_KEY) begin
        if (bus_wdata == KEY_FIRST)
          st <= K_HALF;
        else if (bus_wdata == KEY_SECOND && st == K_HALF)
          st <= K_OPEN;
        else
          st <= K_IDLE;
      end else begin
        // any other register write consumes or cancels the key
        st <= K_IDLE;
      end
    end
  end

  assign armed = (st == K_OPEN);

endmodule

// File: rtl/dstore_prog_timer.sv
module dstore_prog_timer #(
  parameter int WR_LAT = 20
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic busy,
  output logic done
);

  localparam int CNT_W = (WR_LAT > 1) ? $clog2(WR_LAT) : 1;
  localparam logic [CNT_W-1:0] LOAD = CNT_W'(WR_LAT - 1);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (busy) begin
      if (cnt == '0)
        busy <= 1'b0;
      else
        cnt <= cnt - 1'b1;
    end else if (start) begin
      busy <= 1'b1;
      cnt  <= LOAD;
    end
  end

  assign done = busy && (cnt == '0);

endmodule

// File: rtl/dstore_array.sv
module dstore_array #(
  parameter int DEPTH = 128,
  parameter int AW    = 7,
  parameter int DW    = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we)
      mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re)
      rdata <= mem[raddr];
  end

endmodule

// File: rtl/dstore_ctl.sv
module dstore_ctl
  import dstore_pkg::*;
#(
  parameter int DEPTH  = 128,
  parameter int WR_LAT = 20
) (
  input  logic       clk,
  input  logic       rst_por,
  input  logic       rst_warm,
  input  logic [1:0] bus_sel,
  input  logic       bus_we,
  input  logic [7:0] bus_wdata,
  input  logic       bus_re,
  output logic [7:0] bus_rdata,
  input  logic       irq_enable,
  input  logic       flag_clr,
  output logic       done_flag,
  output logic       irq
);

  localparam int AW = $clog2(DEPTH);

  logic          any_rst;
  logic [AW-1:0] addr_q;
  logic [7:0]    data_q;
  logic          wren_q;
  logic          rd_q;
  logic          err_q;
  logic          flag_q;
  logic          key_open;
  logic          busy;
  logic          done;
  logic          start;
  logic          rd_go;
  logic          ctrl_we;
  logic [7:0]    arr_q;
  logic [7:0]    ctrl_view;

  assign any_rst = rst_por | rst_warm;
  assign ctrl_we = bus_we && (bus_sel == RA_CTRL);
  assign start   = ctrl_we && bus_wdata[C_WR] && bus_wdata[C_WREN] && key_open && !busy;
  assign rd_go   = ctrl_we && bus_wdata[C_RD] && !busy && !rd_q;

  dstore_unlock u_key (
    .clk       (clk),
    .rst       (any_rst),
    .bus_we    (bus_we),
    .bus_sel   (bus_sel),
    .bus_wdata (bus_wdata),
    .armed     (key_open)
  );

  dstore_prog_timer #(.WR_LAT(WR_LAT)) u_tmr (
    .clk   (clk),
    .rst   (any_rst),
    .start (start),
    .busy  (busy),
    .done  (done)
  );

  dstore_array #(.DEPTH(DEPTH), .AW(AW), .DW(8)) u_arr (
    .clk   (clk),
    .we    (done),
    .waddr (addr_q),
    .wdata (data_q),
    .re    (rd_go),
    .raddr (addr_q),
    .rdata (arr_q)
  );

  always_ff @(posedge clk) begin
    if (any_rst)
      addr_q <= '0;
    else if (bus_we && bus_sel == RA_ADDR && !busy)
      addr_q <= bus_wdata[AW-1:0];
  end

  always_ff @(posedge clk) begin
    if (any_rst)
      data_q <= '0;
    else if (rd_q)
      data_q <= arr_q;
    else if (bus_we && bus_sel == RA_DATA && !busy)
      data_q <= bus_wdata;
  end

  always_ff @(posedge clk) begin
    if (any_rst)
      rd_q <= 1'b0;
    else if (rd_q)
      rd_q <= 1'b0;
    else if (rd_go)
      rd_q <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (any_rst)
      wren_q <= 1'b0;
    else if (ctrl_we)
      wren_q <= bus_wdata[C_WREN];
  end

  always_ff @(posedge clk) begin
    if (rst_por)
      err_q <= 1'b0;
    else if (rst_warm) begin
      if (busy)
        err_q <= 1'b1;
    end else if (done)
      err_q <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (any_rst)
      flag_q <= 1'b0;
    else if (done)
      flag_q <= 1'b1;
    else if (flag_clr)
      flag_q <= 1'b0;
  end

  assign ctrl_view = {4'b0000, err_q, wren_q, busy, rd_q};

  always_ff @(posedge clk) begin
    if (any_rst)
      bus_rdata <= 8'h00;
    else if (bus_re) begin
      case (bus_sel)
        RA_ADDR: bus_rdata <= 8'(addr_q);
        RA_DATA: bus_rdata <= data_q;
        RA_CTRL: bus_rdata <= ctrl_view;
        default: bus_rdata <= 8'h00;
      endcase
    end
  end

  assign done_flag = flag_q;
  assign irq       = flag_q & irq_enable;

endmodule

// File: rtl/dstore_ctl_chk.sv
module dstore_ctl_chk
  import dstore_pkg::*;
#(
  parameter int AW = 7
) (
  input logic          clk,
  input logic          rst_por,
  input logic          rst_warm,
  input logic [1:0]    bus_sel,
  input logic          bus_we,
  input logic          bus_re,
  input logic [7:0]    bus_rdata,
  input logic          done_flag,
  input logic          flag_clr,
  input logic          busy,
  input logic          armed,
  input logic [AW-1:0] addr_q,
  input logic          err_q
);

  // R5
  start_needs_key_chk: assert property (@(posedge clk) disable iff (rst_por)
    $rose(busy) |-> $past(armed));

  // R7
  flag_after_busy_chk: assert property (@(posedge clk) disable iff (rst_por)
    $rose(done_flag) |-> $past(busy));

  // R8
  addr_frozen_chk: assert property (@(posedge clk) disable iff (rst_por)
    (busy && bus_we && bus_sel == RA_ADDR && !rst_warm) |=> $stable(addr_q));

  // R10
  abort_err_chk: assert property (@(posedge clk) disable iff (rst_por)
    (busy && rst_warm) |=> err_q);

  // R9
  flag_hold_chk: assert property (@(posedge clk) disable iff (rst_por)
    (done_flag && !flag_clr && !rst_warm) |=> done_flag);

  // R2
  key_reads_zero_chk: assert property (@(posedge clk) disable iff (rst_por)
    (bus_re && bus_sel == RA_KEY && !rst_warm) |=> (bus_rdata == 8'h00));

endmodule

bind dstore_ctl dstore_ctl_chk #(.AW(AW)) u_chk (
  .clk       (clk),
  .rst_por   (rst_por),
  .rst_warm  (rst_warm),
  .bus_sel   (bus_sel),
  .bus_we    (bus_we),
  .bus_re    (bus_re),
  .bus_rdata (bus_rdata),
  .done_flag (done_flag),
  .flag_clr  (flag_clr),
  .busy      (busy),
  .armed     (key_open),
  .addr_q    (addr_q),
  .err_q     (err_q)
);

// File: tb/dstore_ctl_test.sv
module dstore_ctl_test;

  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 128;
  localparam int WR_LAT     = 8;

  localparam logic [1:0] S_ADDR = 2'd0;
  localparam logic [1:0] S_DATA = 2'd1;
  localparam logic [1:0] S_CTRL = 2'd2;
  localparam logic [1:0] S_KEY  = 2'd3;

  logic       clk = 1'b0;
  logic       rst_por = 1'b1;
  logic       rst_warm = 1'b0;
  logic [1:0] bus_sel = 2'd0;
  logic       bus_we = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic       bus_re = 1'b0;
  logic [7:0] bus_rdata;
  logic       irq_enable = 1'b0;
  logic       flag_clr = 1'b0;
  logic       done_flag;
  logic       irq;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;
  logic [7:0] exp_mem [DEPTH];

  always #(CLK_PERIOD/2) clk = ~clk;

  dstore_ctl #(.DEPTH(DEPTH), .WR_LAT(WR_LAT)) uut (
    .clk(clk), .rst_por(rst_por), .rst_warm(rst_warm),
    .bus_sel(bus_sel), .bus_we(bus_we), .bus_wdata(bus_wdata),
    .bus_re(bus_re), .bus_rdata(bus_rdata),
    .irq_enable(irq_enable), .flag_clr(flag_clr),
    .done_flag(done_flag), .irq(irq)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  // all tasks start and end at a falling edge
  task automatic wr(input logic [1:0] sel, input logic [7:0] val);
    bus_sel = sel; bus_wdata = val; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] sel, output logic [7:0] val);
    bus_sel = sel; bus_re = 1'b1;
    @(negedge clk);
    bus_re = 1'b0;
    val = bus_rdata;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // polls control until bit 1 is clear, returns the number of busy reads
  task automatic wait_idle(output int busy_cnt);
    logic [7:0] v;
    busy_cnt = 0;
    for (int i = 0; i < 4*WR_LAT + 8; i++) begin
      rd(S_CTRL, v);
      if (!v[1]) break;
      busy_cnt++;
    end
  endtask

  task automatic clr_flag();
    flag_clr = 1'b1;
    @(negedge clk);
    flag_clr = 1'b0;
  endtask

  task automatic prog(input logic [7:0] a, input logic [7:0] d, output int busy_cnt);
    wr(S_ADDR, a);
    wr(S_DATA, d);
    wr(S_CTRL, 8'h04);
    wr(S_KEY, 8'h55);
    wr(S_KEY, 8'hAA);
    wr(S_CTRL, 8'h06);
    wait_idle(busy_cnt);
  endtask

  task automatic peek(input logic [7:0] a, output logic [7:0] v);
    logic [7:0] c;
    wr(S_ADDR, a);
    wr(S_CTRL, 8'h01);
    rd(S_CTRL, c);
    rd(S_DATA, v);
  endtask

  task automatic warm_pulse();
    rst_warm = 1'b1;
    @(negedge clk);
    rst_warm = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: got 0x00 expected 0x01");
      $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    logic [7:0] c;
    int bc;

    @(negedge clk); @(negedge clk); @(negedge clk);
    rst_por = 1'b0;
    @(negedge clk);

    // R1 reset state
    rd(S_ADDR, v); check("R1 addr", v, 8'h00);
    rd(S_DATA, v); check("R1 data", v, 8'h00);
    rd(S_CTRL, v); check("R1 ctrl", v, 8'h00);
    check("R1 flag", {7'd0, done_flag}, 8'h00);
    check("R1 irq", {7'd0, irq}, 8'h00);

    // R2 key reads zero, upper control bits zero
    wr(S_KEY, 8'h55);
    rd(S_KEY, v); check("R2 key", v, 8'h00);
    wr(S_CTRL, 8'hF4);
    rd(S_CTRL, v); check("R2 ctrl high", v, 8'h04);

    // R7 sweep of every location with latency check
    for (int a = 0; a < DEPTH; a++) begin
      exp_mem[a] = 8'(a * 37 + 11);
      prog(8'(a), exp_mem[a], bc);
      check("R7 latency", 8'(bc), 8'(WR_LAT));
      check("R7 flag", {7'd0, done_flag}, 8'h01);
      clr_flag();
    end
    // R3 read-back sweep
    for (int a = 0; a < DEPTH; a++) begin
      peek(8'(a), v);
      check("R3 readback", v, exp_mem[a]);
    end

    // R3 read request timing
    wr(S_ADDR, 8'd9);
    wr(S_CTRL, 8'h01);
    rd(S_CTRL, c); check("R3 rd bit set", c & 8'h01, 8'h01);
    rd(S_CTRL, c); check("R3 rd bit clear", c & 8'h01, 8'h00);
    rd(S_DATA, v); check("R3 data", v, exp_mem[9]);

    // R4 start without key
    wr(S_ADDR, 8'd20);
    wr(S_DATA, 8'hE1);
    wr(S_CTRL, 8'h06);
    rd(S_CTRL, c); check("R4 no key ctrl", c, 8'h04);
    peek(8'd20, v); check("R4 no key mem", v, exp_mem[20]);

    // R5 reversed key, wrong byte, no enable
    wr(S_ADDR, 8'd21); wr(S_DATA, 8'h3C);
    wr(S_KEY, 8'hAA); wr(S_KEY, 8'h55); wr(S_CTRL, 8'h06);
    rd(S_CTRL, c); check("R5 reversed", c & 8'h02, 8'h00);
    wr(S_KEY, 8'h55); wr(S_KEY, 8'hAB); wr(S_CTRL, 8'h06);
    rd(S_CTRL, c); check("R5 wrong byte", c & 8'h02, 8'h00);
    wr(S_KEY, 8'h55); wr(S_KEY, 8'hAA); wr(S_CTRL, 8'h02);
    rd(S_CTRL, c); check("R5 no enable", c, 8'h00);
    idle(WR_LAT + 2);
    peek(8'd21, v); check("R5 mem", v, exp_mem[21]);

    // R6 intervening writes
    wr(S_ADDR, 8'd22);
    wr(S_KEY, 8'h55); wr(S_DATA, 8'h77); wr(S_KEY, 8'hAA); wr(S_CTRL, 8'h06);
    rd(S_CTRL, c); check("R6 gap one", c & 8'h02, 8'h00);
    wr(S_KEY, 8'h55); wr(S_KEY, 8'hAA); wr(S_ADDR, 8'd22); wr(S_CTRL, 8'h06);
    rd(S_CTRL, c); check("R6 gap two", c & 8'h02, 8'h00);
    idle(WR_LAT + 2);
    peek(8'd22, v); check("R6 mem", v, exp_mem[22]);

    // R8 and R4: hammer registers during a write
    wr(S_ADDR, 8'd30); wr(S_DATA, 8'h5A); wr(S_CTRL, 8'h04);
    wr(S_KEY, 8'h55); wr(S_KEY, 8'hAA); wr(S_CTRL, 8'h06);
    wr(S_ADDR, 8'd31);
    wr(S_DATA, 8'hC3);
    wr(S_CTRL, 8'h04);
    rd(S_CTRL, c); check("R4 busy not clearable", c & 8'h02, 8'h02);
    wr(S_KEY, 8'h55);
    wr(S_KEY, 8'hAA);
    wr(S_CTRL, 8'h07);
    wait_idle(bc);
    exp_mem[30] = 8'h5A;
    rd(S_CTRL, c); check("R8 no restart", c & 8'h03, 8'h00);
    rd(S_ADDR, v); check("R8 addr kept", v, 8'd30);
    rd(S_DATA, v); check("R8 data kept", v, 8'h5A);
    peek(8'd30, v); check("R8 target", v, 8'h5A);
    peek(8'd31, v); check("R8 other", v, exp_mem[31]);

    // R9 flag and interrupt
    check("R9 flag set", {7'd0, done_flag}, 8'h01);
    check("R9 irq masked", {7'd0, irq}, 8'h00);
    irq_enable = 1'b1;
    #1;
    check("R9 irq on", {7'd0, irq}, 8'h01);
    idle(3);
    check("R9 flag held", {7'd0, done_flag}, 8'h01);
    clr_flag();
    check("R9 flag cleared", {7'd0, done_flag}, 8'h00);
    check("R9 irq off", {7'd0, irq}, 8'h00);
    irq_enable = 1'b0;

    // R10 and R11: abort a write with the warm reset
    wr(S_ADDR, 8'd40); wr(S_DATA, 8'h99); wr(S_CTRL, 8'h04);
    wr(S_KEY, 8'h55); wr(S_KEY, 8'hAA); wr(S_CTRL, 8'h06);
    idle(2);
    warm_pulse();
    rd(S_CTRL, c); check("R10 err after abort", c, 8'h08);
    rd(S_ADDR, v); check("R11 addr", v, 8'h00);
    rd(S_DATA, v); check("R11 data", v, 8'h00);
    check("R11 flag", {7'd0, done_flag}, 8'h00);
    idle(WR_LAT + 2);
    check("R10 no flag", {7'd0, done_flag}, 8'h00);
    peek(8'd40, v); check("R10 byte kept", v, exp_mem[40]);
    warm_pulse();
    rd(S_CTRL, c); check("R10 idle warm keeps err", c, 8'h08);
    prog(8'd41, 8'h12, bc);
    exp_mem[41] = 8'h12;
    rd(S_CTRL, c); check("R10 completion clears err", c, 8'h04);
    clr_flag();
    peek(8'd41, v); check("R10 new byte", v, 8'h12);

    // R10 power-on reset clears err
    wr(S_CTRL, 8'h04); wr(S_KEY, 8'h55); wr(S_KEY, 8'hAA); wr(S_CTRL, 8'h06);
    warm_pulse();
    rd(S_CTRL, c); check("R10 err set again", c, 8'h08);
    rst_por = 1'b1;
    @(negedge clk);
    rst_por = 1'b0;
    rd(S_CTRL, c); check("R10 por clears err", c, 8'h00);

    finished = 1;
    $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule